// File: doc/BRIEF.md
# Coalescing Interrupt Cause Controller

This block gathers single-cycle hardware event pulses into a 32-bit main cause register and a second, sparser register that records DMA-channel events. Each cause stays pending until software clears it by writing a one to its position. DMA causes are summarised into three bits of the main cause view: receive, transmit and error. An enable mask selects which main causes may drive the single interrupt request output.

The request is not raised the moment a cause becomes pending. A coalescing timer, programmed in ticks of about 32 microseconds, lets further events collect first, so one interrupt covers several of them. A pending high-priority receive event skips this wait. A separate periodic timer can set a dedicated receive cause at a programmable interval. A flat register port gives write access and combinational read access to the cause, enable, DMA cause, coalescing and periodic registers. The tick comes from a prescaler on the system clock. The prescaler ratio is a parameter, so a simulation can use a short tick.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: A pulse on `hw_evt_i[n]` sets main cause bit n. The bit stays set until a register write to address 0 carries a one in bit n. A zero written at that position leaves the bit unchanged. If an event and a clear hit the same bit in the same cycle, the event wins.
- R2: `irq_o` may be raised only by main cause bits whose enable bit (address 1) is one. Setting an enable bit for a cause that is already pending raises the request two clock edges after the write, when the coalescing value is zero.
- R3: The DMA cause register (address 2) stores only bits 31 (error), 30 (high-priority receive), 17 and 16 (receive channels 1 and 0), and 1 and 0 (transmit channels 1 and 0). Writing ones clears these bits. Events on any other bit are ignored and read back as zero.
- R4: The main cause read value (address 0) shows DMA summaries:
  - bit 29 is set while DMA bit 31 is pending;
  - bit 31 is set while any of DMA bits 30, 17 or 16 is pending;
  - bit 27 is set while DMA bit 1 or bit 0 is pending.
- R5: The coalescing value (address 3, bits 7:0) resets to 0x40. A nonzero value N holds the request back for N prescaler ticks after the first enabled cause becomes pending while no request is active.
- R6: With a coalescing value of 0, `irq_o` rises on the second clock edge after an enabled event pulse is sampled.
- R7: While DMA bit 30 is pending and enable bit 31 is set, `irq_o` is high from the next clock edge onward, whatever the coalescing value or the time already waited.
- R8: The periodic value (address 4, bits 7:0) resets to 0, and the value 0 disables the periodic timer. A nonzero value P sets main cause bit 28 once every P ticks.
- R9: `irq_o` falls on the clock edge after the enabled pending causes have all been cleared. The next enabled event starts a fresh coalescing wait.
- R10: After reset, `irq_o` is low and these values read back: main cause 0, enable 0, DMA cause 0, coalescing 0x40, periodic 0.

Addresses 3 and 4 read back as their 8-bit value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt_i | input | 32 | One-cycle event pulses into the main cause register |
| dma_evt_i | input | 32 | One-cycle DMA event pulses into the DMA cause register |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 main cause, 1 enable, 2 DMA cause, 3 coalescing, 4 periodic |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse sampled at edge E appears in the cause read value just after E. With zero coalescing, the request follows at edge E+1, and the bench checks the low-then-high transition at the two negative edges that follow.

Clearing the last enabled cause at edge C drops the request at C+1, so the bench expects it still high after C and low after C+1.

The coalescing delay depends on the phase of the free-running prescaler. The bench therefore counts negative edges until the request and accepts a window of one tick width around N ticks.

Periodic and masking results are read through the register port only after enough edges for the timer or mask to have taken effect.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int CAUSE_W = 32;
    localparam int TIMER_W = 8;
    localparam int ADDR_W  = 3;

    localparam logic [TIMER_W-1:0] COAL_RESET = 8'h40;

    // main cause summary and timer positions
    localparam int MAIN_RX_SUM   = 31;
    localparam int MAIN_DMA_ERR  = 29;
    localparam int MAIN_PERIODIC = 28;
    localparam int MAIN_TX_SUM   = 27;

    // DMA cause positions
    localparam int DMA_ERR   = 31;
    localparam int DMA_HIPRI = 30;
    localparam int DMA_RX1   = 17;
    localparam int DMA_RX0   = 16;
    localparam int DMA_TX1   = 1;
    localparam int DMA_TX0   = 0;

    localparam logic [CAUSE_W-1:0] DMA_VALID =
        (CAUSE_W'(1) << DMA_ERR) | (CAUSE_W'(1) << DMA_HIPRI) |
        (CAUSE_W'(1) << DMA_RX1) | (CAUSE_W'(1) << DMA_RX0) |
        (CAUSE_W'(1) << DMA_TX1) | (CAUSE_W'(1) << DMA_TX0);

    typedef enum logic [ADDR_W-1:0] {
        SEL_CAUSE  = 3'd0,
        SEL_ENABLE = 3'd1,
        SEL_DMA    = 3'd2,
        SEL_COAL   = 3'd3,
        SEL_PERIOD = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        CO_IDLE = 2'd0,
        CO_WAIT = 2'd1,
        CO_FIRE = 2'd2
    } coal_state_e;

endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int DIV = 1600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/irq_period_timer.sv
module irq_period_timer
    import irq_coal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               restart_i,
    input  logic [TIMER_W-1:0] period_i,
    output logic               fire_o
);
    typedef struct packed {
        logic [TIMER_W-1:0] cnt;
        logic               fire;
    } per_st_t;

    per_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (restart_i || (period_i == '0)) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt + TIMER_W'(1) >= period_i) begin
                st_d.cnt  = '0;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + TIMER_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = st_q.fire;
endmodule

// File: rtl/irq_coal_fsm.sv
module irq_coal_fsm
    import irq_coal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [TIMER_W-1:0] coal_i,
    input  logic               pending_i,
    input  logic               bypass_i,
    output logic               irq_o
);
    typedef struct packed {
        coal_state_e        state;
        logic [TIMER_W-1:0] cnt;
        logic               irq;
    } coal_st_t;

    coal_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            CO_IDLE: begin
                if (pending_i) begin
                    if (bypass_i || (coal_i == '0)) begin
                        st_d.state = CO_FIRE;
                    end else begin
                        st_d.state = CO_WAIT;
                        st_d.cnt   = coal_i;
                    end
                end
            end
            CO_WAIT: begin
                if (!pending_i) begin
                    st_d.state = CO_IDLE;
                end else if (bypass_i) begin
                    st_d.state = CO_FIRE;
                end else if (tick_i) begin
                    if (st_q.cnt <= TIMER_W'(1)) st_d.state = CO_FIRE;
                    else                         st_d.cnt   = st_q.cnt - TIMER_W'(1);
                end
            end
            CO_FIRE: begin
                if (!pending_i) st_d.state = CO_IDLE;
            end
            default: st_d.state = CO_IDLE;
        endcase
        st_d.irq = (st_d.state == CO_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= CO_IDLE;
            st_q.cnt   <= '0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irq_coal_pkg::*;
#(
    parameter int TICK_DIV = 1600
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] hw_evt_i,
    input  logic [CAUSE_W-1:0] dma_evt_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [CAUSE_W-1:0] reg_wdata_i,
    output logic [CAUSE_W-1:0] reg_rdata_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [CAUSE_W-1:0] enable;
        logic [CAUSE_W-1:0] dma;
        logic [TIMER_W-1:0] coal;
        logic [TIMER_W-1:0] period;
    } regs_t;

    regs_t regs_d, regs_q;

    logic               tick;
    logic               per_fire;
    logic               cause_wr, enable_wr, dma_wr, coal_wr, period_wr;
    logic [CAUSE_W-1:0] fold;
    logic [CAUSE_W-1:0] eff_cause;
    logic [CAUSE_W-1:0] cause_q;
    logic               pending;
    logic               bypass;
    logic               period_zero;

    assign cause_wr  = reg_we_i && (reg_sel_e'(reg_addr_i) == SEL_CAUSE);
    assign enable_wr = reg_we_i && (reg_sel_e'(reg_addr_i) == SEL_ENABLE);
    assign dma_wr    = reg_we_i && (reg_sel_e'(reg_addr_i) == SEL_DMA);
    assign coal_wr   = reg_we_i && (reg_sel_e'(reg_addr_i) == SEL_COAL);
    assign period_wr = reg_we_i && (reg_sel_e'(reg_addr_i) == SEL_PERIOD);

    // DMA summaries folded into the main cause view
    always_comb begin
        fold               = '0;
        fold[MAIN_DMA_ERR] = regs_q.dma[DMA_ERR];
        fold[MAIN_RX_SUM]  = regs_q.dma[DMA_HIPRI] | regs_q.dma[DMA_RX1] | regs_q.dma[DMA_RX0];
        fold[MAIN_TX_SUM]  = regs_q.dma[DMA_TX1] | regs_q.dma[DMA_TX0];
    end

    assign eff_cause   = regs_q.cause | fold;
    assign cause_q     = regs_q.cause;
    assign pending     = |(eff_cause & regs_q.enable);
    assign bypass      = regs_q.dma[DMA_HIPRI] & regs_q.enable[MAIN_RX_SUM];
    assign period_zero = (regs_q.period == '0);

    always_comb begin
        logic [CAUSE_W-1:0] clr_main, clr_dma, per_set;
        clr_main = cause_wr ? reg_wdata_i : '0;
        clr_dma  = dma_wr   ? reg_wdata_i : '0;
        per_set  = '0;
        per_set[MAIN_PERIODIC] = per_fire;

        regs_d       = regs_q;
        regs_d.cause = (regs_q.cause & ~clr_main) | hw_evt_i | per_set;
        regs_d.dma   = ((regs_q.dma & ~clr_dma) | dma_evt_i) & DMA_VALID;
        if (enable_wr) regs_d.enable = reg_wdata_i;
        if (coal_wr)   regs_d.coal   = reg_wdata_i[TIMER_W-1:0];
        if (period_wr) regs_d.period = reg_wdata_i[TIMER_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cause  <= '0;
            regs_q.enable <= '0;
            regs_q.dma    <= '0;
            regs_q.coal   <= COAL_RESET;
            regs_q.period <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr_i))
            SEL_CAUSE:  reg_rdata_o = eff_cause;
            SEL_ENABLE: reg_rdata_o = regs_q.enable;
            SEL_DMA:    reg_rdata_o = regs_q.dma;
            SEL_COAL:   reg_rdata_o = CAUSE_W'(regs_q.coal);
            SEL_PERIOD: reg_rdata_o = CAUSE_W'(regs_q.period);
            default:    reg_rdata_o = '0;
        endcase
    end

    irq_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    irq_period_timer i_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .restart_i (period_wr),
        .period_i  (regs_q.period),
        .fire_o    (per_fire)
    );

    irq_coal_fsm i_coal (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .coal_i    (regs_q.coal),
        .pending_i (pending),
        .bypass_i  (bypass),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        pending,
    input logic        bypass,
    input logic        cause_wr,
    input logic [31:0] cause_q,
    input logic        per_fire,
    input logic        period_zero
);
    // R1: without a clear write, no set cause bit is lost
    assert_cause_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R2: the request only rises out of an enabled pending cause
    assert_rise_needs_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pending));

    // R7: high-priority receive forces the request on the next edge
    assert_hipri_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> irq);

    // R8: a zero period never fires
    assert_period_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_zero |=> !per_fire);

    // R9: no enabled pending cause drops the request next edge
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq);
endmodule

bind irq_coalesce_ctrl irq_coalesce_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq_o),
    .pending     (pending),
    .bypass      (bypass),
    .cause_wr    (cause_wr),
    .cause_q     (cause_q),
    .per_fire    (per_fire),
    .period_zero (period_zero)
);

// File: tb/test_irq_coalesce_ctrl.sv
`timescale 1ns/1ps
module test_irq_coalesce_ctrl;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_evt = '0;
    logic [31:0] dma_evt = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    irq_coalesce_ctrl #(.TICK_DIV(DIV)) i_irq_coalesce_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_evt_i    (hw_evt),
        .dma_evt_i   (dma_evt),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {dma pulse, expected main cause view, expected DMA readback}
    localparam logic [95:0] FOLD_VEC [7] = '{
        {32'h8000_0000, 32'h2000_0000, 32'h8000_0000},
        {32'h4000_0000, 32'h8000_0000, 32'h4000_0000},
        {32'h0002_0000, 32'h8000_0000, 32'h0002_0000},
        {32'h0001_0000, 32'h8000_0000, 32'h0001_0000},
        {32'h0000_0002, 32'h0800_0000, 32'h0000_0002},
        {32'h0000_0001, 32'h0800_0000, 32'h0000_0001},
        {32'h0004_0100, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic pulse_hw(input logic [31:0] v);
        @(negedge clk); hw_evt = v;
        @(negedge clk); hw_evt = '0;
    endtask

    task automatic pulse_dma(input logic [31:0] v);
        @(negedge clk); dma_evt = v;
        @(negedge clk); dma_evt = '0;
    endtask

    task automatic measure_coal(input string req);
        int n;
        n = 0;
        pulse_hw(32'h1);
        while (!irq && n < 100) begin
            @(negedge clk);
            n++;
        end
        compared++;
        if (n < 2 * DIV + 1 || n > 3 * DIV + 2) begin
            mismatched++;
            $display("FAIL %s: irq after %0d edges, expected %0d..%0d",
                     req, n, 2 * DIV + 1, 3 * DIV + 2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 irq", {31'b0, irq}, 32'h0);
        rd(3'd0, d); chk("R10 cause", d, 32'h0);
        rd(3'd1, d); chk("R10 enable", d, 32'h0);
        rd(3'd2, d); chk("R10 dma", d, 32'h0);
        rd(3'd3, d); chk("R10 R5 coal default", d, 32'h40);
        rd(3'd4, d); chk("R10 R8 period default", d, 32'h0);

        // R3 R4 fold table
        for (int i = 0; i < 7; i++) begin
            pulse_dma(FOLD_VEC[i][95:64]);
            rd(3'd0, d); chk("R4 fold view", d, FOLD_VEC[i][63:32]);
            rd(3'd2, d); chk("R3 dma readback", d, FOLD_VEC[i][31:0]);
            wr(3'd2, 32'hFFFF_FFFF);
            rd(3'd0, d); chk("R3 dma clear", d, 32'h0);
        end

        // R1 write-one-to-clear
        pulse_hw(32'h0000_0009);
        rd(3'd0, d); chk("R1 set", d, 32'h9);
        wr(3'd0, 32'h0);
        rd(3'd0, d); chk("R1 zero write", d, 32'h9);
        wr(3'd0, 32'h1);
        rd(3'd0, d); chk("R1 clear one", d, 32'h8);
        wr(3'd0, 32'h8);
        rd(3'd0, d); chk("R1 clear rest", d, 32'h0);

        // R6 zero coalescing
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h1);
        @(negedge clk); hw_evt = 32'h1;
        @(negedge clk); hw_evt = '0;
        chk("R6 irq low after first edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R6 irq high after second edge", {31'b0, irq}, 32'h1);

        // R9 deassert timing and rearm
        @(negedge clk); we = 1'b1; addr = 3'd0; wdata = 32'h1;
        @(negedge clk); we = 1'b0; wdata = '0;
        chk("R9 irq held at clear edge", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 irq dropped", {31'b0, irq}, 32'h0);
        pulse_hw(32'h1);
        @(negedge clk);
        chk("R9 rearm", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h0);

        // R2 mask gating
        pulse_hw(32'h8);
        repeat (5) @(negedge clk);
        chk("R2 masked cause", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h8);
        chk("R2 one edge after enable", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R2 two edges after enable", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h8);
        @(negedge clk);
        chk("R2 R9 cleared", {31'b0, irq}, 32'h0);

        // R5 coalescing window, twice
        wr(3'd3, 32'h3);
        wr(3'd1, 32'h1);
        measure_coal("R5 first wait");
        wr(3'd0, 32'h1);
        @(negedge clk);
        measure_coal("R5 R9 rearmed wait");
        wr(3'd0, 32'h1);

        // R7 high-priority bypass
        wr(3'd3, 32'hFF);
        wr(3'd1, 32'h8000_0000);
        pulse_dma(32'h0001_0000);
        repeat (20) @(negedge clk);
        chk("R5 ordinary rx still coalescing", {31'b0, irq}, 32'h0);
        pulse_dma(32'h4000_0000);
        chk("R7 one edge after hipri", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 bypass raised", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 R9 dropped", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h0);
        rd(3'd3, d); chk("R5 coal readback", d, 32'hFF);

        // R8 periodic
        wr(3'd4, 32'h2);
        rd(3'd4, d); chk("R8 period readback", d, 32'h2);
        repeat (3 * DIV) @(negedge clk);
        rd(3'd0, d); chk("R8 periodic bit", d, 32'h1000_0000);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        repeat (10 * DIV) @(negedge clk);
        rd(3'd0, d); chk("R8 disabled", d, 32'h0);
        chk("R8 no irq", {31'b0, irq}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule